// File: doc/BRIEF.md
# Prefetching Byte FIFO with Grant Tracking

This block is a small single-clock byte FIFO that sits between a shared DMA engine and a byte consumer. It fetches ahead: it raises a request towards the engine, the engine grants it, and the granted byte arrives some cycles later on a valid strobe. The block counts the grants that have not yet been followed by a delivered byte. It stops requesting once stored bytes plus outstanding grants would reach its capacity, so every byte that was granted always has a free slot when it arrives.

The consumer side is a plain valid/ready stream. The head byte stays on the data lines until the consumer takes it. A synchronous clear input drops all stored bytes and forgets all outstanding grants in one cycle. Clear is meant for aborting a transfer after the engine has been stopped.

Top module: `prefetch_fifo`

## Requirements
- R1: After reset the FIFO is empty. `headValid` is 0, and `fillReady` and `fetchReq` are both 1.
- R2: `fillReady` is 1 exactly when fewer than DEPTH bytes (default 2) are stored.
- R3: `fetchReq` is 1 exactly when `fillReady` is 1 and stored bytes plus outstanding grants are fewer than DEPTH.
- R4: The outstanding-grant count changes as follows. A cycle with `fetchReq` and `fetchGnt` both high and no accepted byte adds one. A cycle with an accepted byte (`fillValid` and `fillReady` both high) and no grant subtracts one, stopping at zero. A cycle with both a grant and an accepted byte leaves the count unchanged.
- R5: A byte is stored when `fillValid` and `fillReady` are both high. A byte offered while the FIFO is full is ignored and does not change the stored contents.
- R6: `headValid` is 1 whenever at least one byte is stored. While `headValid` is 1 and `headReady` is 0, `headData` holds its value.
- R7: Bytes leave on `headData` in the order they were accepted. The head advances by one byte on each cycle in which `headValid` and `headReady` are both high.
- R8: A cycle with `clrI` high empties the storage and zeroes the outstanding-grant count. Clear takes priority over any push, pop or grant in that same cycle.
- R9: A cycle that both accepts a byte and removes one leaves the number of stored bytes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| clrI | input | 1 | Synchronous clear of storage and grant count |
| fetchReq | output | 1 | Request for one more byte from the DMA engine |
| fetchGnt | input | 1 | Engine accepts the request in this cycle |
| fillValid | input | 1 | A fetched byte is present on `fillData` |
| fillData | input | WIDTH | Fetched byte |
| fillReady | output | 1 | Storage has room for a byte |
| headValid | output | 1 | `headData` carries the oldest stored byte |
| headData | output | WIDTH | Oldest stored byte |
| headReady | input | 1 | Consumer takes the head byte |

## Verification
Several properties are checked on every cycle by the embedded assertions:
- stored bytes plus outstanding grants never exceed the depth;
- a lone grant raises the count;
- clear leaves the FIFO empty and requesting;
- a simultaneous push and pop keeps the occupancy;
- a stalled head byte stays unchanged.

Other behaviour can only be shown by the bench's scenarios against its reference model. This covers the exact request gating as grants pile up without data, the dropping of a byte offered when the FIFO is full, the order in which bytes leave, and the saturation of the count when a byte arrives with no grant pending.

// File: rtl/prefetch_pkg.sv
package prefetch_pkg;

  // Strobes issued by the control path to the storage datapath each cycle.
  typedef struct packed {
    logic push;   // write fillData into the tail slot
    logic pop;    // release the head slot
    logic clear;  // drop everything
  } fifoStrobes_t;

endpackage

// File: rtl/fetch_ctrl.sv
module fetch_ctrl
  import prefetch_pkg::*;
#(
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         clrI,
  input  logic         fetchGnt,
  input  logic         fillValid,
  input  logic         headReady,
  output logic         fetchReq,
  output logic         fillReady,
  output logic         headValid,
  output fifoStrobes_t strobes
);

  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int SUM_W = CNT_W + 1;
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [CNT_W-1:0] occCnt;
  logic [CNT_W-1:0] pendCnt;
  logic [SUM_W-1:0] inFlight;
  logic             doPush;
  logic             doPop;
  logic             granted;

  assign fillReady = (occCnt != FULL_CNT);
  assign headValid = (occCnt != '0);
  assign inFlight  = SUM_W'(occCnt) + SUM_W'(pendCnt);
  assign fetchReq  = fillReady && (pendCnt < FULL_CNT) && (inFlight < SUM_W'(DEPTH));

  assign doPush  = fillValid && fillReady && !clrI;
  assign doPop   = headValid && headReady && !clrI;
  assign granted = fetchReq && fetchGnt;

  assign strobes.push  = doPush;
  assign strobes.pop   = doPop;
  assign strobes.clear = clrI;

  // Occupancy tracking
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      occCnt <= '0;
    end else if (clrI) begin
      occCnt <= '0;
    end else begin
      case ({doPush, doPop})
        2'b10:   occCnt <= occCnt + CNT_W'(1);
        2'b01:   occCnt <= occCnt - CNT_W'(1);
        default: occCnt <= occCnt;
      endcase
    end
  end

  // Outstanding grant counter: granted requests not yet delivered
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendCnt <= '0;
    end else if (clrI) begin
      pendCnt <= '0;
    end else if (granted && !doPush) begin
      pendCnt <= pendCnt + CNT_W'(1);
    end else if (doPush && !granted && (pendCnt != '0)) begin
      pendCnt <= pendCnt - CNT_W'(1);
    end
  end

  // R3: granted slots plus stored bytes never exceed storage
  a_r3_no_overrun: assert property (@(posedge clk) disable iff (!rstN)
    (SUM_W'(occCnt) + SUM_W'(pendCnt)) <= SUM_W'(DEPTH));

  // R4: a lone grant raises the outstanding count
  a_r4_grant_counts: assert property (@(posedge clk) disable iff (!rstN)
    (fetchReq && fetchGnt && !(fillValid && fillReady) && !clrI)
    |=> (pendCnt == $past(pendCnt) + CNT_W'(1)));

  // R8: clear leaves the FIFO empty and requesting
  a_r8_clear_empties: assert property (@(posedge clk) disable iff (!rstN)
    clrI |=> (!headValid && fetchReq));

  // R9: simultaneous push and pop keep the occupancy
  a_r9_push_pop_same: assert property (@(posedge clk) disable iff (!rstN)
    (doPush && doPop) |=> (occCnt == $past(occCnt)));

endmodule

// File: rtl/fifo_store.sv
module fifo_store
  import prefetch_pkg::*;
#(
  parameter int DEPTH = 2,
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  fifoStrobes_t     strobes,
  input  logic [WIDTH-1:0] fillData,
  output logic [WIDTH-1:0] headData
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST_SLOT = PTR_W'(DEPTH - 1);

  logic [WIDTH-1:0] slots [DEPTH];
  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] rdPtr;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == LAST_SLOT) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else if (strobes.clear) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strobes.push) wrPtr <= nextPtr(wrPtr);
      if (strobes.pop)  rdPtr <= nextPtr(rdPtr);
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic wrEn;
    assign wrEn = strobes.push && (wrPtr == PTR_W'(i));
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        slots[i] <= '0;
      end else if (wrEn) begin
        slots[i] <= fillData;
      end
    end
  end

  assign headData = slots[rdPtr];

endmodule

// File: rtl/prefetch_fifo.sv
module prefetch_fifo
  import prefetch_pkg::*;
#(
  parameter int DEPTH = 2,
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clrI,
  output logic             fetchReq,
  input  logic             fetchGnt,
  input  logic             fillValid,
  input  logic [WIDTH-1:0] fillData,
  output logic             fillReady,
  output logic             headValid,
  output logic [WIDTH-1:0] headData,
  input  logic             headReady
);

  fifoStrobes_t strobes;

  fetch_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .clrI      (clrI),
    .fetchGnt  (fetchGnt),
    .fillValid (fillValid),
    .headReady (headReady),
    .fetchReq  (fetchReq),
    .fillReady (fillReady),
    .headValid (headValid),
    .strobes   (strobes)
  );

  fifo_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .fillData (fillData),
    .headData (headData)
  );

  // R6: a stalled head byte stays put
  a_r6_head_hold: assert property (@(posedge clk) disable iff (!rstN)
    (headValid && !headReady && !clrI) |=> (headValid && $stable(headData)));

endmodule

// File: tb/sim_prefetch_fifo.sv
`timescale 1ns/1ps
module sim_prefetch_fifo;

  localparam int DEPTH = 2;
  localparam int WIDTH = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic clrI = 1'b0;
  logic fetchGnt = 1'b0;
  logic fillValid = 1'b0;
  logic [WIDTH-1:0] fillData = '0;
  logic headReady = 1'b0;
  logic fetchReq, fillReady, headValid;
  logic [WIDTH-1:0] headData;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 0;

  // reference model state
  logic [WIDTH-1:0] mQ[$];
  int mPend = 0;

  always #2.5 clk = ~clk;

  prefetch_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u0 (
    .clk(clk), .rstN(rstN), .clrI(clrI), .fetchReq(fetchReq), .fetchGnt(fetchGnt),
    .fillValid(fillValid), .fillData(fillData), .fillReady(fillReady),
    .headValid(headValid), .headData(headData), .headReady(headReady)
  );

  function automatic bit expReady();
    return mQ.size() < DEPTH;
  endfunction

  function automatic bit expReq();
    return expReady() && (mPend < DEPTH) && (mQ.size() + mPend < DEPTH);
  endfunction

  task automatic check(string tag, logic [WIDTH-1:0] act, logic [WIDTH-1:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic checkAll(string tag);
    check({tag, " R2 fillReady"}, WIDTH'(fillReady), WIDTH'(expReady()));
    check({tag, " R3 fetchReq"}, WIDTH'(fetchReq), WIDTH'(expReq()));
    check({tag, " R6 headValid"}, WIDTH'(headValid), WIDTH'(mQ.size() > 0));
    if (mQ.size() > 0) check({tag, " R7 headData"}, headData, mQ[0]);
  endtask

  // At a negedge: drive, take the edge, update model, check at next negedge.
  task automatic step(bit gnt, bit fv, logic [WIDTH-1:0] fd, bit hr, bit clr, string tag);
    bit rdy, rq, push, pop, grant;
    fetchGnt = gnt; fillValid = fv; fillData = fd; headReady = hr; clrI = clr;
    rdy = expReady(); rq = expReq();
    @(posedge clk);
    if (clr) begin
      mQ.delete();
      mPend = 0;
    end else begin
      push = fv && rdy;
      pop = hr && (mQ.size() > 0);
      grant = rq && gnt;
      if (pop) void'(mQ.pop_front());
      if (push) mQ.push_back(fd);
      if (grant && !push) mPend++;
      else if (push && !grant && mPend > 0) mPend--;
    end
    @(negedge clk);
    checkAll(tag);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog expired");
    finish();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1 headValid", WIDTH'(headValid), '0);
    check("R1 fillReady", WIDTH'(fillReady), 8'd1);
    check("R1 fetchReq", WIDTH'(fetchReq), 8'd1);

    // R4: two grants with no data stop requests; one delivery keeps them stopped
    step(1, 0, 8'h00, 0, 0, "R4 grant1");
    step(1, 0, 8'h00, 0, 0, "R4 grant2");
    check("R4 req low at two pending", WIDTH'(fetchReq), '0);
    step(0, 1, 8'h11, 0, 0, "R4 deliver1");
    check("R4 req low occ1 pend1", WIDTH'(fetchReq), '0);
    step(0, 0, 8'h00, 1, 0, "R4 pop1");
    check("R4 req back after pop", WIDTH'(fetchReq), 8'd1);
    // grant and delivery together: count unchanged (pend 1)
    step(1, 1, 8'h22, 0, 0, "R4 grant+deliver");
    check("R4 req low occ1 pend1 again", WIDTH'(fetchReq), '0);
    step(0, 1, 8'h33, 0, 0, "R4 drain pend");
    // now full: R5 offer while full is dropped
    check("R5 full not ready", WIDTH'(fillReady), '0);
    step(0, 1, 8'hEE, 0, 0, "R5 offer when full");
    step(0, 0, 8'h00, 1, 0, "R5 pop a");
    check("R5 second byte kept", headData, 8'h33);
    // R9: push and pop same cycle
    step(0, 1, 8'h44, 1, 0, "R9 push+pop");
    check("R9 head after push+pop", headData, 8'h44);
    // R6 hold while stalled
    step(0, 0, 8'h55, 0, 0, "R6 stall");
    check("R6 held head", headData, 8'h44);
    // R8: clear wins over push and grant
    step(1, 1, 8'h66, 1, 1, "R8 clear");
    check("R8 empty after clear", WIDTH'(headValid), '0);
    check("R8 requesting after clear", WIDTH'(fetchReq), 8'd1);
    // R4 saturation: byte with no grant pending
    step(0, 1, 8'h77, 0, 0, "R4 unrequested byte");
    step(0, 0, 8'h00, 1, 0, "R4 drain");
    check("R4 pend stays zero", WIDTH'(fetchReq), 8'd1);

    // Random mix
    void'($urandom(32'h1234_5678));
    for (int i = 0; i < 3000; i++) begin
      bit gnt, fv, hr, clr;
      gnt = ($urandom % 3) != 0;
      fv = (mPend > 0) ? (($urandom % 2) == 1) : (($urandom % 8) == 0);
      hr = ($urandom % 3) != 0;
      clr = ($urandom % 97) == 0;
      step(gnt, fv, WIDTH'($urandom), hr, clr, "R7 random");
    end
    finish();
  end

endmodule